// File: doc/BRIEF.md
# Flash Program Status Poller

This block sits on the host side of a byte-wide flash device. The flash runs its own internal algorithm after a program or erase command. The block waits for that algorithm to finish and then reports whether it succeeded. A single `start` pulse launches it. The pulse latches the target address, the byte that was meant to be written, a method select and an erase select. The block then reads that one address again and again over a simple request/valid read port until it can reach a verdict.

Two completion methods are available:

- **Toggle method.** The block waits for bit 6 to read the same on two reads in a row.
- **Data-polling method.** The block waits for bit 7 to match bit 7 of the intended byte.

In both methods bit 5 is the device's error flag. A set error flag does not fail the operation at once. It triggers one more confirmation, because the completion bit and the error flag can change in the same read. Once completion is seen, one last read compares the whole byte with the intended value. For an erase, the intended value is all ones.

`busy` covers the whole sequence. `pass` or `fail` then stays up until the next start. A poll limit set at build time ends a hung operation with `fail` and a separate `timeout` flag.

Top module: `flash_status_poller`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `busy`, `pass`, `fail`, `timeout` and `rd_req` are all 0.
- R2: When `busy` is low, a `start` pulse is accepted. From the next cycle `busy` is 1, `pass`, `fail` and `timeout` are 0, and `rd_addr` shows the latched `addr`. A `start` while `busy` is 1 has no effect on the running operation or on `rd_addr`.
- R3: Reads happen one at a time. `rd_req` stays 1 until the cycle in which `rd_valid` is 1, and is 0 whenever `busy` is 0. Every read uses the latched address.
- R4: Toggle method (`mode`=0). The first status read only records bit 6. The operation is complete when a status read returns the same bit 6 as the previous status read.
- R5: Toggle method, error case. When a status read differs in bit 6 from the previous one and has bit 5 = 1, the block makes two more reads. If their bit 6 values are equal, the operation is complete. Otherwise the result is fail.
- R6: Data-polling method (`mode`=1). A status read whose bit 7 equals bit 7 of the expected byte means complete. On a mismatch with bit 5 = 0, polling continues. On a mismatch with bit 5 = 1, one more read decides: a bit 7 match means complete, a mismatch means fail.
- R7: After completion, exactly one verify read is made. If the whole byte equals the expected byte the result is `pass`, otherwise `fail`.
- R8: With `erase`=1, the expected byte is all ones (8'hFF) and `exp_data` is ignored.
- R9: If `MAX_POLLS` status reads in the polling phase end without completion or an error recheck, the block stops with `fail`=1 and `timeout`=1. `timeout` is never 1 without `fail`.
- R10: `busy` stays 1 until `pass` or `fail` rises, in the same edge as `busy` falls. `pass` and `fail` are never both 1, and they hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin polling |
| mode | input | 1 | 0 = toggle method, 1 = data-polling method |
| erase | input | 1 | 1 = operation was an erase, so all ones are expected |
| addr | input | ADDR_W | Location to poll |
| exp_data | input | DATA_W | Byte that was programmed |
| rd_req | output | 1 | Read request, held until answered |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | DATA_W | Read data, valid with `rd_valid` |
| busy | output | 1 | Poll sequence in progress |
| pass | output | 1 | Operation completed and verified |
| fail | output | 1 | Operation failed, was unconfirmed or timed out |
| timeout | output | 1 | Failure was caused by the poll limit |

## Verification
The assertions assume three things about the read port:

- `rd_valid` comes only in a cycle where `rd_req` is already high.
- Each request is answered with exactly one `rd_valid` pulse.
- `start` is a single-cycle pulse.

The bench's device model follows all three. It answers only an open request that has not yet been answered, one cycle after it sees that request. It serves bytes from a per-case queue. Starts are driven at the falling edge, and a deliberate second start during a running case is the only start ever issued while `busy` is high.

// File: rtl/fsp_pkg.sv
// Shared types for the flash status poller.
// Assumes a byte-wide device: status flags sit at bits 7, 6 and 5.
package fsp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_TG_A,
        ST_TG_B,
        ST_DP_RE,
        ST_VERIFY,
        ST_DONE
    } fsp_state_e;

    typedef enum logic [1:0] {
        DEC_CONT,
        DEC_VERIFY,
        DEC_RECHECK
    } fsp_dec_e;

    localparam int BIT_POLL = 7;
    localparam int BIT_TOG  = 6;
    localparam int BIT_ERR  = 5;
endpackage

// File: rtl/fsp_read_port.sv
// Single-outstanding read issuer.
// Raises rd_req when the controller wants a read and none is open.
// Drops rd_req on the edge where rd_valid is seen.
// Assumes rd_valid arrives only while rd_req is high.
module fsp_read_port (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic rd_valid,
    output logic rd_req,
    output logic got
);
    logic req_q;

    // Open a request when one is wanted; close it when the answer arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else if (req_q && rd_valid)
            req_q <= 1'b0;
        else if (!req_q && want)
            req_q <= 1'b1;
    end

    // Expose the request and flag the cycle in which it completes.
    always_comb begin
        rd_req = req_q;
        got    = req_q && rd_valid;
    end
endmodule

// File: rtl/fsp_poll_counter.sv
// Counts status reads in the polling phase.
// Flags the read that would use up the limit.
// Assumes MAX_POLLS >= 1.
module fsp_poll_counter #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt;

    // Clear on a new operation; advance once per polling read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    // True while the next polling read is the last one allowed.
    always_comb last = (cnt == LAST_VAL);
endmodule

// File: rtl/fsp_status_eval.sv
// Decides what one polling-phase status byte means for the chosen method.
// Purely combinational.
// Assumes DATA_W >= 8.
module fsp_status_eval
    import fsp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              mode,
    input  logic              have_prev,
    input  logic              prev_tog,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] expect_q,
    output fsp_dec_e          dec
);
    // Toggle: compare bit 6 with the last read. Poll: compare bit 7 with the target.
    always_comb begin
        dec = DEC_CONT;
        if (!mode) begin
            if (have_prev) begin
                if (data[BIT_TOG] == prev_tog)
                    dec = DEC_VERIFY;
                else if (data[BIT_ERR])
                    dec = DEC_RECHECK;
            end
        end else begin
            if (data[BIT_POLL] == expect_q[BIT_POLL])
                dec = DEC_VERIFY;
            else if (data[BIT_ERR])
                dec = DEC_RECHECK;
        end
    end
endmodule

// File: rtl/flash_status_poller.sv
// Flash program/erase status poller.
// Polls one address by the toggle or data-polling method.
// Confirms on an error flag, then verifies the full byte.
// Assumes a single-outstanding read port and a single-cycle start.
module flash_status_poller
    import fsp_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] exp_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              pass,
    output logic              fail,
    output logic              timeout
);
    localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

    fsp_state_e        state;
    fsp_dec_e          dec;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] exp_q;
    logic              mode_q, have_prev, prev_tog;
    logic              want, got, last, accept;

    // Controller wants a read in every reading state; a start is taken when not busy.
    always_comb begin
        want   = (state == ST_POLL) || (state == ST_TG_A) || (state == ST_TG_B) ||
                 (state == ST_DP_RE) || (state == ST_VERIFY);
        busy   = (state != ST_IDLE) && (state != ST_DONE);
        accept = start && !busy;
    end

    fsp_read_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (want),
        .rd_valid (rd_valid),
        .rd_req   (rd_req),
        .got      (got)
    );

    fsp_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (got && (state == ST_POLL)),
        .last  (last)
    );

    fsp_status_eval #(.DATA_W(DATA_W)) u_eval (
        .mode      (mode_q),
        .have_prev (have_prev),
        .prev_tog  (prev_tog),
        .data      (rd_data),
        .expect_q  (exp_q),
        .dec       (dec)
    );

    // Sequence the polling, recheck and verify phases, and register the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            exp_q     <= '0;
            mode_q    <= 1'b0;
            have_prev <= 1'b0;
            prev_tog  <= 1'b0;
            pass      <= 1'b0;
            fail      <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        addr_q    <= addr;
                        exp_q     <= erase ? ERASED : exp_data;
                        mode_q    <= mode;
                        have_prev <= 1'b0;
                        pass      <= 1'b0;
                        fail      <= 1'b0;
                        timeout   <= 1'b0;
                        state     <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (got) begin
                        case (dec)
                            DEC_VERIFY:  state <= ST_VERIFY;
                            DEC_RECHECK: state <= mode_q ? ST_DP_RE : ST_TG_A;
                            default: begin
                                prev_tog  <= rd_data[BIT_TOG];
                                have_prev <= 1'b1;
                                if (last) begin
                                    fail    <= 1'b1;
                                    timeout <= 1'b1;
                                    state   <= ST_DONE;
                                end
                            end
                        endcase
                    end
                end
                ST_TG_A: begin
                    if (got) begin
                        prev_tog <= rd_data[BIT_TOG];
                        state    <= ST_TG_B;
                    end
                end
                ST_TG_B: begin
                    if (got) begin
                        if (rd_data[BIT_TOG] == prev_tog) begin
                            state <= ST_VERIFY;
                        end else begin
                            fail  <= 1'b1;
                            state <= ST_DONE;
                        end
                    end
                end
                ST_DP_RE: begin
                    if (got) begin
                        if (rd_data[BIT_POLL] == exp_q[BIT_POLL]) begin
                            state <= ST_VERIFY;
                        end else begin
                            fail  <= 1'b1;
                            state <= ST_DONE;
                        end
                    end
                end
                ST_VERIFY: begin
                    if (got) begin
                        pass  <= (rd_data == exp_q);
                        fail  <= (rd_data != exp_q);
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Every read targets the latched location.
    always_comb rd_addr = addr_q;
endmodule

// File: rtl/fsp_checker.sv
// Protocol and verdict checks for flash_status_poller.
// Attached to the top module by bind.
// Assumes rd_valid is only given to an open request.
module fsp_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              pass,
    input logic              fail,
    input logic              timeout,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr
);
    AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(pass && fail)); // R10
    AST_BUSY_NO_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !pass && !fail); // R10
    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (pass || fail) && !start |=> $stable(pass) && $stable(fail)); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) rd_req && !rd_valid |=> rd_req); // R3
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !rd_req); // R3
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) |-> $stable(rd_addr)); // R3
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) start && !busy |=> busy && !pass && !fail); // R2
    AST_TIMEOUT_IS_FAIL: assert property (@(posedge clk) disable iff (!rst_n) timeout |-> fail); // R9
endmodule

bind flash_status_poller fsp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .pass     (pass),
    .fail     (fail),
    .timeout  (timeout),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr)
);

// File: tb/sim_flash_status_poller.sv
module sim_flash_status_poller;
    localparam int AW   = 16;
    localparam int MAXP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, mode = 1'b0, erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    exp_data = '0;
    logic          rd_req, rd_valid = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data = '0;
    logic          busy, pass, fail, timeout;

    int n_checks = 0, n_fails = 0, n_reads = 0;
    bit done_flag = 0;
    logic [7:0] dq[$];

    always #10 clk = ~clk;

    flash_status_poller #(.ADDR_W(AW), .DATA_W(8), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .erase(erase),
        .addr(addr), .exp_data(exp_data), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .pass(pass),
        .fail(fail), .timeout(timeout)
    );

    // Device model: answer each open request one cycle later from the queue.
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else if (rd_req && !rd_valid) begin
            rd_valid <= 1'b1;
            rd_data  <= (dq.size() > 0) ? dq.pop_front() : rd_data;
            n_reads  <= n_reads + 1;
        end else begin
            rd_valid <= 1'b0;
        end
    end

    // Behavioural reference: phase 0 idle,1 poll,2 tog-a,3 tog-b,4 poll-recheck,5 verify.
    int         m_phase = 0, m_n = 0;
    bit         m_busy = 0, m_pass = 0, m_fail = 0, m_to = 0, m_have = 0, m_mode = 0;
    logic       m_prev = 0;
    logic [7:0] m_exp = 0;
    logic [AW-1:0] m_addr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_busy = 0; m_pass = 0; m_fail = 0; m_to = 0;
        end else if (!m_busy && start) begin
            m_busy = 1; m_pass = 0; m_fail = 0; m_to = 0; m_have = 0; m_n = 0;
            m_phase = 1; m_mode = mode; m_addr = addr;
            m_exp = erase ? 8'hFF : exp_data;
        end else if (m_busy && rd_req && rd_valid) begin
            if (m_phase == 1) begin
                m_n++;
                if (!m_mode) begin
                    if (m_have && rd_data[6] == m_prev) m_phase = 5;
                    else if (m_have && rd_data[5]) m_phase = 2;
                    else begin m_have = 1; m_prev = rd_data[6]; end
                end else begin
                    if (rd_data[7] == m_exp[7]) m_phase = 5;
                    else if (rd_data[5]) m_phase = 4;
                end
                if (m_phase == 1 && m_n == MAXP) begin
                    m_fail = 1; m_to = 1; m_busy = 0; m_phase = 0;
                end
            end else if (m_phase == 2) begin
                m_prev = rd_data[6]; m_phase = 3;
            end else if (m_phase == 3) begin
                if (rd_data[6] == m_prev) m_phase = 5;
                else begin m_fail = 1; m_busy = 0; m_phase = 0; end
            end else if (m_phase == 4) begin
                if (rd_data[7] == m_exp[7]) m_phase = 5;
                else begin m_fail = 1; m_busy = 0; m_phase = 0; end
            end else if (m_phase == 5) begin
                m_pass = (rd_data == m_exp); m_fail = !m_pass; m_busy = 0; m_phase = 0;
            end
        end
    end

    // Per-clock comparison against the reference (R2, R3, R10 and the verdict flags).
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            n_checks++;
            if (busy !== m_busy || pass !== m_pass || fail !== m_fail || timeout !== m_to) begin
                n_fails++;
                $display("FAIL R10 cycle compare: busy/pass/fail/to=%b%b%b%b expected %b%b%b%b",
                         busy, pass, fail, timeout, m_busy, m_pass, m_fail, m_to);
            end
            if (rd_req && rd_addr !== m_addr) begin
                n_fails++;
                $display("FAIL R3 rd_addr=%h expected %h", rd_addr, m_addr);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input string req, input bit md, input bit er, input logic [AW-1:0] a,
                            input logic [7:0] ed, input logic [7:0] seq[$], input bit e_pass,
                            input bit e_fail, input bit e_to, input int e_reads, input bit poke);
        int r0;
        dq = seq;
        r0 = n_reads;
        @(negedge clk);
        start = 1; mode = md; erase = er; addr = a; exp_data = ed;
        @(negedge clk);
        start = 0;
        check({req, " R2 busy after start"}, busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1; mode = ~md; addr = ~a; exp_data = ~ed;
            @(negedge clk);
            start = 0;
            check("R2 rd_addr unchanged by start while busy", int'(rd_addr), int'(a));
        end
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
        check({req, " pass"}, pass, e_pass);
        check({req, " fail"}, fail, e_fail);
        check({req, " timeout"}, timeout, e_to);
        check({req, " read count"}, n_reads - r0, e_reads);
        repeat (2) @(negedge clk);
        check({req, " R10 verdict held"}, pass + 2 * fail, e_pass + 2 * e_fail);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1 busy in reset", busy, 0);
        check("R1 pass/fail in reset", pass | fail, 0);
        check("R1 timeout/rd_req in reset", timeout | rd_req, 0);
        rst_n = 1;
        // R4: toggle 40,00,40,40 -> stable, verify A5
        run_case("R4 toggle pass", 0, 0, 16'h1234, 8'hA5, '{8'h40, 8'h00, 8'h40, 8'h40, 8'hA5}, 1, 0, 0, 5, 0);
        // R7: stable but verify byte wrong
        run_case("R7 verify mismatch", 0, 0, 16'h0010, 8'hA5, '{8'h00, 8'h00, 8'hA4}, 0, 1, 0, 3, 0);
        // R5: error flag, recheck still toggling
        run_case("R5 recheck fail", 0, 0, 16'h0020, 8'h5A, '{8'h40, 8'h20, 8'h60, 8'h20}, 0, 1, 0, 4, 0);
        // R5: error flag, recheck stable -> verify
        run_case("R5 recheck ok", 0, 0, 16'h0030, 8'hA5, '{8'h40, 8'h20, 8'h20, 8'h20, 8'hA5}, 1, 0, 0, 5, 0);
        // R6: data poll 05,05,85 then verify 85
        run_case("R6 poll pass", 1, 0, 16'h0040, 8'h85, '{8'h05, 8'h05, 8'h85, 8'h85}, 1, 0, 0, 4, 0);
        // R6: error then match
        run_case("R6 error then match", 1, 0, 16'h0050, 8'h85, '{8'h25, 8'h85, 8'h85}, 1, 0, 0, 3, 0);
        // R6: error then mismatch
        run_case("R6 error then mismatch", 1, 0, 16'h0060, 8'h85, '{8'h25, 8'h25}, 0, 1, 0, 2, 0);
        // R8: erase, exp_data ignored, expect FF
        run_case("R8 erase poll", 1, 1, 16'h0070, 8'h12, '{8'h00, 8'h80, 8'hFF}, 1, 0, 0, 3, 0);
        run_case("R8 erase toggle verify", 0, 1, 16'h0071, 8'hFF, '{8'h40, 8'h40, 8'h7F}, 0, 1, 0, 3, 0);
        // R9: toggling forever -> timeout after MAXP reads
        run_case("R9 timeout", 0, 0, 16'h0080, 8'hA5,
                 '{8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00}, 0, 1, 1, MAXP, 0);
        // R2: start while busy ignored
        run_case("R2 ignore start", 0, 0, 16'h0BEE, 8'h3C, '{8'h40, 8'h00, 8'h40, 8'h00, 8'h00, 8'h3C}, 1, 0, 0, 6, 1);
        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule